// File: doc/BRIEF.md
# Dual-Clock FIFO with First-Word-Fall-Through Output

This block moves data words from one clock domain to another through a small dual-port store. The producer writes on its own clock with a write strobe and a data bus. The consumer reads on an unrelated clock with a read strobe and sees the data on a registered output. Write and read pointers cross the boundary as Gray code through a chain of synchronising flops. All flags are derived from those synchronised copies, so every flag that a remote event raises shows a fixed number of cycles of latency.

A static mode input picks one of two read behaviours. In standard mode, a word reaches the output only in the read cycle that asks for it. In fall-through mode, the oldest stored word is placed on the output as soon as it is known to the read side, and the empty flag drops together with it. A read request then consumes that word and pulls up the next one in the same edge. The read side also reports almost-empty against a parameterised level, which defaults to four words. The write side raises a full flag that blocks any further writes.

Top module: `dual_clock_fifo`

## Requirements
- R1: While reset is held, and after reset until the first write, `empty` and `almost_empty` read 1, `full` reads 0 and `rd_data` reads 0.
- R2: Words leave the FIFO in exactly the order they were accepted. The first word written after reset is the first word read.
- R3: In standard mode (`fwft_mode`=0), `empty` falls on the third rising `rd_clk` edge after the `wr_clk` edge that wrote into an empty FIFO. When the two edges nearly coincide, the fourth is also allowed.
- R4: In fall-through mode (`fwft_mode`=1), `empty` falls one read edge later than in standard mode (fourth, or fifth when edges nearly coincide). At that point `rd_data` already holds the first word, with no read request.
- R5: In standard mode, a stored word does not appear on `rd_data` until a read is accepted. After the accepting `rd_clk` edge, `rd_data` holds that word.
- R6: `almost_empty` is 1 while fewer than AE_LEVEL (default 4) words are held. When the AE_LEVEL-th word is written, it falls on the third (or fourth) rising `rd_clk` edge after that write edge. In standard mode it is always 1 when `empty` is 1.
- R7: In fall-through mode, a read taken while `rd_data` is valid consumes that word. The next stored word appears on `rd_data` at the same edge. If no stored word remains, `empty` rises at that edge.
- R8: Pointers cross domains as Gray code, changing by at most one bit per clock. Each crossing passes through SYNC_STAGES (default 2) flops.
- R9: A read request while `empty` is 1 and a write request while `full` is 1 are ignored. Neither moves a pointer nor changes the stored data or `rd_data` (in standard mode).
- R10: `full` rises at the write edge that stores the DEPTH-th unread word. The read pointer never passes the write pointer, and no word is overwritten.
- R11: In standard mode, `empty` rises at the `rd_clk` edge that accepts the last stored word, with no synchronisation delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_mode | input | 1 | 0 = standard read, 1 = first-word-fall-through; static outside reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free location; writes are ignored |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| empty | output | 1 | No word available to read |
| almost_empty | output | 1 | Fewer than AE_LEVEL words held |

## Verification
The assertions assume that `fwft_mode` only changes while reset is held. They also assume that reset is asserted in both domains together, and that the two clocks never share an edge. A shared edge would make the synchroniser latency ambiguous by a cycle. The stimulus only changes the mode inside a reset window. It runs the read clock at the same rate as the write clock with a fixed quarter-period skew, and it changes every input one time unit after the edge of its own domain. Flag latencies are therefore measured against a stable phase, and each is still accepted with one extra read cycle.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   typedef enum logic {
      MODE_STANDARD = 1'b0,
      MODE_FALLTHRU = 1'b1
   } dcf_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
   parameter int ADDR_W = 4,
   localparam int PW = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PW-1:0]     rgray_sync,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [PW-1:0]     wbin,
   output logic [PW-1:0]     wgray,
   output logic              full
);
   logic [PW-1:0] wbin_nxt, wgray_nxt, full_pattern;

   assign we           = wr_en && !full;
   assign wbin_nxt     = wbin + PW'(we);
   assign wgray_nxt    = wbin_nxt ^ (wbin_nxt >> 1);
   assign full_pattern = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};
   assign waddr        = wbin[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         full  <= 1'b0;
      end else begin
         wbin  <= wbin_nxt;
         wgray <= wgray_nxt;
         full  <= (wgray_nxt == full_pattern);
      end
   end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
   import dcf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 4,
   parameter int AE_LEVEL = 4,
   localparam int PW = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwft_mode,
   input  logic              rd_en,
   input  logic [PW-1:0]     wgray_sync,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] raddr,
   output logic [PW-1:0]     rbin,
   output logic [PW-1:0]     rgray,
   output logic [PW-1:0]     wbin_seen,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              almost_empty
);
   dcf_mode_e     mode;
   logic          store_empty, out_valid, out_valid_nxt;
   logic          take_req, take;
   logic [PW-1:0] rbin_nxt, level_nxt;

   assign mode = dcf_mode_e'(fwft_mode);

   for (genvar i = 0; i < PW; i++) begin : g_g2b
      assign wbin_seen[i] = ^wgray_sync[PW-1:i];
   end

   always_comb begin
      take_req = (mode == MODE_FALLTHRU) ? (!out_valid || rd_en) : rd_en;
      take     = take_req && !store_empty;
      rbin_nxt = rbin + PW'(take);
      if (mode == MODE_FALLTHRU)
         out_valid_nxt = take ? 1'b1 : (rd_en ? 1'b0 : out_valid);
      else
         out_valid_nxt = 1'b0;
      level_nxt = (wbin_seen - rbin_nxt) + PW'(out_valid_nxt);
   end

   assign raddr = rbin[ADDR_W-1:0];
   assign empty = (mode == MODE_FALLTHRU) ? !out_valid : store_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin         <= '0;
         rgray        <= '0;
         store_empty  <= 1'b1;
         out_valid    <= 1'b0;
         almost_empty <= 1'b1;
         rd_data      <= '0;
      end else begin
         rbin         <= rbin_nxt;
         rgray        <= rbin_nxt ^ (rbin_nxt >> 1);
         store_empty  <= (rbin_nxt == wbin_seen);
         out_valid    <= out_valid_nxt;
         almost_empty <= (level_nxt < PW'(AE_LEVEL));
         if (take) rd_data <= mem_rdata;
      end
   end
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int AE_LEVEL    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              fwft_mode,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              almost_empty
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PW    = ADDR_W + 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (AE_LEVEL < 1 || AE_LEVEL > DEPTH) begin : g_bad_ae
      $error("AE_LEVEL must lie in 1..DEPTH");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic              we;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [DATA_W-1:0] mem_rdata;
   logic [PW-1:0]     wbin, wgray, rbin, rgray, wgray_sync, rgray_sync, wbin_seen;

   dcf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rgray_sync(rgray_sync),
      .we(we), .waddr(waddr), .wbin(wbin), .wgray(wgray), .full(full)
   );

   dcf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(mem_rdata)
   );

   dcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_sync)
   );

   dcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_sync)
   );

   dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode), .rd_en(rd_en),
      .wgray_sync(wgray_sync), .mem_rdata(mem_rdata), .raddr(raddr),
      .rbin(rbin), .rgray(rgray), .wbin_seen(wbin_seen), .rd_data(rd_data),
      .empty(empty), .almost_empty(almost_empty)
   );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   localparam int PW = ADDR_W + 1
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              fwft_mode,
   input logic              wr_en,
   input logic              full,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              empty,
   input logic              almost_empty,
   input logic [PW-1:0]     wbin,
   input logic [PW-1:0]     wgray,
   input logic [PW-1:0]     rgray,
   input logic [PW-1:0]     rbin,
   input logic [PW-1:0]     wbin_seen
);
   localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

   // R8: each crossing pointer moves by at most one Gray bit per clock
   assert_wgray_step_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $onehot0(wgray ^ $past(wgray)));
   assert_rgray_step_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $onehot0(rgray ^ $past(rgray)));

   // R9: write while full leaves the write pointer in place
   assert_full_ignore_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en && full) |=> $stable(wbin));

   // R9: standard-mode read while empty changes neither pointer nor output
   assert_empty_ignore_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!fwft_mode && rd_en && empty) |=> ($stable(rd_data) && $stable(rbin)));

   // R4: a presented fall-through word stays put until it is read
   assert_fwft_hold_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (fwft_mode && !empty && !rd_en) |=> (!empty && $stable(rd_data)));

   // R10: reader never runs ahead of the writer and never trails by more than DEPTH
   assert_no_overrun_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
      ((wbin_seen - rbin) <= DEPTH_V));

   // R6: in standard mode an empty FIFO is also almost empty
   assert_empty_ae_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!fwft_mode && empty) |-> almost_empty);
endmodule

bind dual_clock_fifo dcf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
   .wr_en(wr_en), .full(full), .rd_en(rd_en), .rd_data(rd_data),
   .empty(empty), .almost_empty(almost_empty), .wbin(wbin), .wgray(wgray),
   .rgray(rgray), .rbin(rbin), .wbin_seen(wbin_seen)
);

// File: tb/tb_dual_clock_fifo.sv
module tb_dual_clock_fifo;
   localparam int DW    = 8;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;

   logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0, fwft_mode = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          full, empty, almost_empty;

   int            n_chk = 0, n_err = 0;
   bit            done = 1'b0, std_pend = 1'b0;
   logic [DW-1:0] exp_q [$];

   dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(4), .SYNC_STAGES(2)) dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
      .wr_en(wr_en), .wr_data(wr_data), .full(full), .rd_en(rd_en),
      .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
   );

   always #10 wr_clk = ~wr_clk;
   initial begin
      #5;
      forever #10 rd_clk = ~rd_clk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // scoreboard monitor, samples at the falling read edge
   always @(negedge rd_clk) begin
      if (rst_n) begin
         if (std_pend) begin
            if (exp_q.size() == 0) chk(1'b0, "R2", "std read with no expected word", rd_data, -1);
            else chk(rd_data == exp_q[0], "R2/R5", "std read word", rd_data, exp_q[0]);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
            std_pend = 1'b0;
         end
         if (rd_en && !empty) begin
            if (fwft_mode) begin
               if (exp_q.size() == 0) chk(1'b0, "R2", "fwft read with no expected word", rd_data, -1);
               else begin
                  chk(rd_data == exp_q[0], "R2/R7", "fwft read word", rd_data, exp_q[0]);
                  void'(exp_q.pop_front());
               end
            end else std_pend = 1'b1;
         end
      end
   end

   task automatic wr_sync(); @(posedge wr_clk); #1; endtask
   task automatic rd_sync(); @(posedge rd_clk); #1; endtask

   // driver: caller stands one unit after a write edge
   task automatic wr_word(input logic [DW-1:0] d);
      wr_data = d;
      wr_en   = 1'b1;
      if (!full) exp_q.push_back(d);
      @(posedge wr_clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic rd_words(input int n);
      rd_en = 1'b1;
      repeat (n) @(posedge rd_clk);
      #1;
      rd_en = 1'b0;
   endtask

   task automatic meas(output int n, input bit on_ae);
      n = 0;
      for (int k = 0; k < 12; k++) begin
         @(posedge rd_clk);
         #1;
         n++;
         if (on_ae ? !almost_empty : !empty) break;
      end
   endtask

   task automatic do_reset(input logic mode);
      #3 rst_n = 1'b0;
      fwft_mode = mode;
      exp_q.delete();
      std_pend = 1'b0;
      #50;
      @(posedge wr_clk);
      #2 rst_n = 1'b1;
   endtask

   task automatic stream(input int base);
      fork
         begin
            wr_sync();
            for (int i = 0; i < 40; i++) begin
               while (full) wr_sync();
               wr_word(DW'(base + i));
            end
         end
         begin
            rd_sync();
            for (int k = 0; k < 400; k++) begin
               rd_en = (k % 3 != 1);
               rd_sync();
            end
            rd_en = 1'b0;
         end
      join
      repeat (4) rd_sync();
      chk(exp_q.size() == 0, "R2", "stream drained", exp_q.size(), 0);
   endtask

   task automatic ae_test(input int base);
      int n;
      wr_sync();
      for (int i = 0; i < 3; i++) wr_word(DW'(base + i));
      repeat (10) rd_sync();
      chk(almost_empty == 1'b1, "R6", "almost_empty with 3 words", almost_empty, 1);
      chk(empty == 1'b0, "R6", "not empty with 3 words", empty, 0);
      wr_sync();
      wr_word(DW'(base + 3));
      meas(n, 1'b1);
      chk(n == 3 || n == 4, "R6", "almost_empty fall latency", n, 3);
      rd_sync();
      rd_words(4);
      chk(empty == 1'b1, "R11/R7", "empty at last read edge", empty, 1);
      rd_sync();
   endtask

   initial begin
      int n;
      logic [DW-1:0] held;
      // ---------------- standard mode ----------------
      #20;
      chk(empty == 1'b1 && almost_empty == 1'b1, "R1", "flags in reset", {empty, almost_empty}, 3);
      do_reset(1'b0);
      rd_sync();
      chk(empty == 1'b1, "R1", "empty after reset", empty, 1);
      chk(almost_empty == 1'b1, "R1", "almost_empty after reset", almost_empty, 1);
      chk(full == 1'b0, "R1", "full after reset", full, 0);
      chk(rd_data == '0, "R1", "rd_data after reset", rd_data, 0);

      wr_sync();
      wr_word(8'hA5);
      meas(n, 1'b0);
      chk(n == 3 || n == 4, "R3", "std empty fall latency", n, 3);
      repeat (3) rd_sync();
      chk(rd_data == '0, "R5", "word hidden before read", rd_data, 0);
      rd_words(1);
      chk(rd_data == 8'hA5, "R5", "word after accepting edge", rd_data, 8'hA5);
      chk(empty == 1'b1, "R11", "empty at last read edge", empty, 1);
      rd_sync();

      ae_test(8'h10);

      // R9: reads while empty
      held = rd_data;
      rd_words(3);
      chk(rd_data == held, "R9", "rd_data unchanged by empty reads", rd_data, held);
      chk(empty == 1'b1, "R9", "still empty after empty reads", empty, 1);
      wr_sync();
      wr_word(8'h3C);
      meas(n, 1'b0);
      rd_words(1);
      chk(rd_data == 8'h3C, "R9", "next word after empty reads", rd_data, 8'h3C);
      rd_sync();

      // R10: fill, overfill, drain
      wr_sync();
      for (int i = 0; i < DEPTH; i++) wr_word(DW'(8'h40 + i));
      chk(full == 1'b1, "R10", "full after DEPTH writes", full, 1);
      wr_word(8'hEE);
      chk(full == 1'b1, "R10", "full held after ignored write", full, 1);
      chk(exp_q.size() == DEPTH, "R9", "ignored write not queued", exp_q.size(), DEPTH);
      repeat (6) rd_sync();
      rd_words(DEPTH);
      chk(empty == 1'b1, "R11", "empty after draining full FIFO", empty, 1);
      repeat (3) rd_sync();
      chk(exp_q.size() == 0, "R10", "all stored words read, overflow word absent", exp_q.size(), 0);

      stream(8'h80);

      // ---------------- fall-through mode ----------------
      do_reset(1'b1);
      rd_sync();
      chk(empty == 1'b1 && rd_data == '0, "R1", "fwft reset state", {empty, rd_data}, 256);
      wr_sync();
      wr_word(8'h11);
      meas(n, 1'b0);
      chk(n == 4 || n == 5, "R4", "fwft empty fall latency", n, 4);
      chk(rd_data == 8'h11, "R4", "first word shown without read", rd_data, 8'h11);
      wr_sync();
      wr_word(8'h22);
      repeat (6) rd_sync();
      chk(rd_data == 8'h11, "R4", "shown word held without read", rd_data, 8'h11);
      rd_words(1);
      chk(rd_data == 8'h22 && empty == 1'b0, "R7", "next word at consuming edge", rd_data, 8'h22);
      rd_words(1);
      chk(empty == 1'b1, "R7", "empty rises when last word taken", empty, 1);
      rd_sync();

      ae_test(8'h50);

      rd_words(3);
      chk(empty == 1'b1, "R9", "fwft empty reads ignored", empty, 1);
      wr_sync();
      wr_word(8'h5A);
      meas(n, 1'b0);
      chk(rd_data == 8'h5A, "R9", "fwft word after empty reads", rd_data, 8'h5A);
      rd_words(1);
      rd_sync();

      stream(8'hC0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule